// File: doc/BRIEF.md
# Oscillation Stop Guard

This block monitors an external clock. It uses a free-running internal oscillator as its only time base. The external clock level passes through a two-flop synchroniser into the internal domain, where rising edges are picked out. A gap counter measures the time since the last rising edge. When detection is enabled and the gap reaches its limit, the block declares an oscillation stop.

A declared stop always sets a sticky status flag. If the reset-enable bit is also set, the stop starts a fixed-length internal reset pulse. That pulse clears both enable bits but leaves the flag alone, so software can read the cause of the reset after release. Only an external reset, or a register write that puts either enable bit at 0, clears the flag.

While detection is on, the block suppresses any request to halt the clock. It also keeps a separate sticky indicator of the lock-up condition: a stop detected with reset disabled while the processor runs from the external clock.

Top module: `osc_stop_guard`

## Requirements
- R1: While `ext_rst` is high at a clock edge, `stop_flag`, `forbidden`, `det_en`, `rst_en` and `int_rst` are all 0 after that edge.
- R2: A stop is declared only while detection is enabled, on the 16th consecutive `clk_int` cycle in which no synchronised rising edge is seen. The synchronised rising edge is seen two cycles after `ext_clk` is first sampled high. A rising-edge spacing of 14 cycles therefore never declares a stop, and a spacing of 18 cycles does.
- R3: A declared stop sets `stop_flag` to 1 on the next edge, whatever the value of `rst_en`.
- R4: A stop declared while `rst_en` is 1 raises `int_rst` for exactly 8 consecutive cycles, starting at the next edge, and `stop_flag` reads 1 after the pulse ends.
- R5: A register write (`cfg_wr` high) with `cfg_det` = 0 or `cfg_rst` = 0 clears `stop_flag`, unless a stop is declared in the same cycle.
- R6: Register writes made while `int_rst` is high are ignored: the enables stay 0 and the flag keeps its value.
- R7: `stp_block` equals `det_en`, and `stp_go` is `stp_req` when `det_en` is 0 and 0 otherwise.
- R8: The internal reset clears `det_en` and `rst_en` to 0 for its whole duration and does not change `stop_flag`.
- R9: A stop declared with `rst_en` = 0 while `cpu_on_ext` is 1 sets `forbidden`. Only `ext_rst` clears `forbidden`.
- R10: Outside internal reset, a register write loads `det_en` from `cfg_det` and `rst_en` from `cfg_rst` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock, the time base for the whole block |
| ext_rst | input | 1 | External reset, synchronous and active high |
| ext_clk | input | 1 | External oscillator being monitored (asynchronous) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_det | input | 1 | Detect-enable value to write |
| cfg_rst | input | 1 | Reset-enable value to write |
| cpu_on_ext | input | 1 | Processor currently runs from the external clock |
| stp_req | input | 1 | Request to halt the clock |
| det_en | output | 1 | Current detect-enable bit |
| rst_en | output | 1 | Current reset-enable bit |
| stop_flag | output | 1 | Sticky oscillation-stop status |
| int_rst | output | 1 | Internal reset pulse |
| forbidden | output | 1 | Sticky lock-up condition indicator |
| stp_block | output | 1 | Halt request is being suppressed |
| stp_go | output | 1 | Halt request allowed to take effect |

## Verification
The assertions take for granted that `ext_rst` is applied before the first check. They also take for granted that the gap limit exceeds two cycles, so that a seen edge cannot be followed at once by a timeout.

The stimulus changes every input on the falling edge of `clk_int`. It drives `ext_clk` as a whole number of internal cycles per half period, or holds it low. This makes edge timing exact, lets the reference model follow the synchroniser delay cycle by cycle, and allows gaps to be chosen on either side of the limit.

// File: rtl/osd_pkg.sv
package osd_pkg;

    typedef struct packed {
        logic det;
        logic rst;
    } osd_cfg_t;

    typedef enum logic [1:0] {
        EV_NONE       = 2'd0,
        EV_STOP_FLAG  = 2'd1,
        EV_STOP_RESET = 2'd2
    } osd_ev_e;

    // A write clears the status flag when it turns either enable off.
    function automatic logic write_clears_flag(osd_cfg_t c);
        return !c.det || !c.rst;
    endfunction

    function automatic osd_ev_e classify(logic stop, osd_cfg_t c);
        if (!stop)     return EV_NONE;
        else if (c.rst) return EV_STOP_RESET;
        else            return EV_STOP_FLAG;
    endfunction

endpackage

// File: rtl/osd_edge_sync.sv
module osd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/osd_timeout.sv
module osd_timeout #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rise,
    output logic stop_det
);
    localparam int GW = $clog2(LIMIT + 1);

    logic [GW-1:0] gap;

    assign stop_det = en && !rise && (gap == GW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || rise)   gap <= '0;
        else if (gap != GW'(LIMIT)) gap <= gap + 1'b1;
    end

    AST_NO_STOP_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !stop_det); // R2

    AST_NO_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |-> !stop_det); // R2

endmodule

// File: rtl/osd_ctrl.sv
module osd_ctrl
    import osd_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     stop_det,
    input  logic     wr_en,
    input  osd_cfg_t wr_cfg,
    input  logic     cpu_on_ext,
    output osd_cfg_t cfg,
    output logic     stop_flag,
    output logic     int_rst,
    output logic     forbidden
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic [RW-1:0] rst_cnt;
    logic          in_rst;
    osd_ev_e       ev;

    assign in_rst  = (rst_cnt != '0);
    assign int_rst = in_rst;
    assign ev      = classify(stop_det, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_cnt <= '0;
            cfg     <= '0;
        end else if (ev == EV_STOP_RESET) begin
            rst_cnt <= RW'(RST_CYCLES);
            cfg     <= '0;
        end else if (in_rst) begin
            rst_cnt <= rst_cnt - 1'b1;
            cfg     <= '0;
        end else if (wr_en) begin
            cfg     <= wr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                                stop_flag <= 1'b0;
        else if (ev != EV_NONE)                                 stop_flag <= 1'b1;
        else if (wr_en && !in_rst && write_clears_flag(wr_cfg)) stop_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                                   forbidden <= 1'b0;
        else if (ev == EV_STOP_FLAG && cpu_on_ext) forbidden <= 1'b1;
    end

    AST_FLAG_SET_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> stop_flag); // R3

    AST_FLAG_HELD_IN_RST: assert property (@(posedge clk) disable iff (rst)
        int_rst && $past(int_rst) |-> $stable(stop_flag)); // R8

    AST_ENABLES_OFF_IN_RST: assert property (@(posedge clk) disable iff (rst)
        int_rst |-> (cfg == '0)); // R8

    AST_FORBID_STICKY: assert property (@(posedge clk) disable iff (rst)
        forbidden |=> forbidden); // R9

    AST_RST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        stop_det && cfg.rst |=> int_rst); // R4

endmodule

// File: rtl/osc_stop_guard.sv
module osc_stop_guard
    import osd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_LIMIT   = 16,
    parameter int RST_CYCLES  = 8
) (
    input  logic clk_int,
    input  logic ext_rst,
    input  logic ext_clk,
    input  logic cfg_wr,
    input  logic cfg_det,
    input  logic cfg_rst,
    input  logic cpu_on_ext,
    input  logic stp_req,
    output logic det_en,
    output logic rst_en,
    output logic stop_flag,
    output logic int_rst,
    output logic forbidden,
    output logic stp_block,
    output logic stp_go
);
    logic     rise;
    logic     stop_det;
    osd_cfg_t cfg;
    osd_cfg_t wr_cfg;

    assign wr_cfg = '{det: cfg_det, rst: cfg_rst};

    osd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_int),
        .rst      (ext_rst),
        .async_in (ext_clk),
        .rise     (rise)
    );

    osd_timeout #(.LIMIT(GAP_LIMIT)) u_timeout (
        .clk      (clk_int),
        .rst      (ext_rst),
        .en       (cfg.det),
        .rise     (rise),
        .stop_det (stop_det)
    );

    osd_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk        (clk_int),
        .rst        (ext_rst),
        .stop_det   (stop_det),
        .wr_en      (cfg_wr),
        .wr_cfg     (wr_cfg),
        .cpu_on_ext (cpu_on_ext),
        .cfg        (cfg),
        .stop_flag  (stop_flag),
        .int_rst    (int_rst),
        .forbidden  (forbidden)
    );

    assign det_en    = cfg.det;
    assign rst_en    = cfg.rst;
    assign stp_block = cfg.det;
    assign stp_go    = stp_req && !cfg.det;

    AST_HALT_SUPPRESSED: assert property (@(posedge clk_int) disable iff (ext_rst)
        stp_block |-> !stp_go); // R7

endmodule

// File: tb/osc_stop_guard_tb.sv
module osc_stop_guard_tb_top;
    localparam int CLK_P = 10;

    logic clk_int = 1'b0;
    logic ext_rst = 1'b1;
    logic ext_clk = 1'b0;
    logic cfg_wr = 1'b0, cfg_det = 1'b0, cfg_rst = 1'b0;
    logic cpu_on_ext = 1'b0, stp_req = 1'b0;
    logic det_en, rst_en, stop_flag, int_rst, forbidden, stp_block, stp_go;

    int checks = 0;
    int fails  = 0;
    int ext_half = 0;
    bit done = 0;

    always #(CLK_P/2) clk_int = ~clk_int;

    osc_stop_guard dut_i (
        .clk_int(clk_int), .ext_rst(ext_rst), .ext_clk(ext_clk),
        .cfg_wr(cfg_wr), .cfg_det(cfg_det), .cfg_rst(cfg_rst),
        .cpu_on_ext(cpu_on_ext), .stp_req(stp_req),
        .det_en(det_en), .rst_en(rst_en), .stop_flag(stop_flag),
        .int_rst(int_rst), .forbidden(forbidden),
        .stp_block(stp_block), .stp_go(stp_go)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // External clock generator, driven on falling edges of clk_int
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk_int);
            if (ext_half == 0) begin
                ext_clk = 1'b0;
                cnt = 0;
            end else begin
                cnt++;
                if (cnt >= ext_half) begin
                    ext_clk = ~ext_clk;
                    cnt = 0;
                end
            end
        end
    end

    // Behavioural reference model
    int m_x1, m_x2, m_x3, m_gap, m_left;
    bit m_det, m_ren, m_flag, m_forb;

    always @(posedge clk_int) begin
        bit edge_seen, stop, old_det, old_ren, in_r;
        if (ext_rst) begin
            m_x1 = 0; m_x2 = 0; m_x3 = 0; m_gap = 0; m_left = 0;
            m_det = 0; m_ren = 0; m_flag = 0; m_forb = 0;
        end else begin
            old_det   = m_det;
            old_ren   = m_ren;
            in_r      = (m_left > 0);
            edge_seen = (m_x2 == 1) && (m_x3 == 0);
            stop      = old_det && !edge_seen && (m_gap == 15);
            if (!old_det || edge_seen) m_gap = 0;
            else if (m_gap < 16)       m_gap++;
            if (stop && old_ren) begin
                m_left = 8; m_det = 0; m_ren = 0;
            end else if (in_r) begin
                m_left--; m_det = 0; m_ren = 0;
            end else if (cfg_wr) begin
                m_det = cfg_det; m_ren = cfg_rst;
            end
            if (stop) m_flag = 1;
            else if (cfg_wr && !in_r && (!cfg_det || !cfg_rst)) m_flag = 0;
            if (stop && !old_ren && cpu_on_ext) m_forb = 1;
            m_x3 = m_x2; m_x2 = m_x1; m_x1 = ext_clk;
        end
    end

    // Per-cycle comparison, a quarter period after the edge
    always @(posedge clk_int) begin
        #(CLK_P/4);
        if (!done) begin
            chk("R3 stop_flag", stop_flag, m_flag);
            chk("R4 int_rst", int_rst, m_left > 0);
            chk("R10 det_en", det_en, m_det);
            chk("R10 rst_en", rst_en, m_ren);
            chk("R9 forbidden", forbidden, m_forb);
            chk("R7 stp_block", stp_block, m_det);
            chk("R7 stp_go", stp_go, stp_req && !m_det);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk_int);
    endtask

    task automatic wr(bit d, bit r);
        @(negedge clk_int);
        cfg_wr = 1; cfg_det = d; cfg_rst = r;
        @(negedge clk_int);
        cfg_wr = 0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int pulse;
        cyc(4);
        ext_rst = 0;
        cyc(1);
        // R1 reset state
        chk("R1 stop_flag", stop_flag, 0);
        chk("R1 forbidden", forbidden, 0);
        chk("R1 int_rst", int_rst, 0);
        chk("R1 det_en", det_en, 0);

        // R2 running clock, no stop
        ext_half = 3;
        wr(1, 0);
        chk("R10 det_en written", det_en, 1);
        cyc(100);
        chk("R2 no stop while running", stop_flag, 0);
        stp_req = 1;
        cyc(1);
        chk("R7 halt blocked", stp_go, 0);
        stp_req = 0;

        // R3/R9 stop with reset disabled, cpu on external clock
        cpu_on_ext = 1;
        ext_half = 0;
        cyc(30);
        chk("R3 flag on stop", stop_flag, 1);
        chk("R9 forbidden set", forbidden, 1);
        chk("R3 no reset", int_rst, 0);
        cpu_on_ext = 0;

        // R5 clearing write
        wr(0, 1);
        chk("R5 flag cleared", stop_flag, 0);
        stp_req = 1;
        cyc(1);
        chk("R7 halt allowed", stp_go, 1);
        stp_req = 0;

        // R4/R8 stop with reset enabled
        wr(1, 1);
        pulse = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            if (int_rst) pulse++;
        end
        chk("R4 pulse length", pulse, 8);
        chk("R4 flag after release", stop_flag, 1);
        chk("R8 det_en cleared", det_en, 0);
        chk("R8 rst_en cleared", rst_en, 0);
        chk("R9 forbidden survives", forbidden, 1);

        // R6 write during internal reset ignored
        wr(1, 1);
        while (!int_rst) cyc(1);
        wr(0, 0);
        chk("R6 enables stay off", det_en, 0);
        while (int_rst) cyc(1);
        chk("R6 flag kept", stop_flag, 1);

        // R2 gap boundaries
        ext_half = 7;
        wr(1, 0);
        cyc(120);
        chk("R2 spacing 14 no stop", stop_flag, 0);
        ext_half = 9;
        cyc(60);
        chk("R2 spacing 18 stops", stop_flag, 1);

        // R2 detection off never declares
        wr(0, 0);
        ext_half = 0;
        cyc(40);
        chk("R2 off no stop", stop_flag, 0);

        // R1 external reset clears sticky state
        wr(1, 0);
        cpu_on_ext = 1;
        cyc(30);
        chk("R3 flag set again", stop_flag, 1);
        @(negedge clk_int);
        ext_rst = 1;
        cyc(2);
        ext_rst = 0;
        cyc(1);
        chk("R1 flag cleared by ext reset", stop_flag, 0);
        chk("R1 forbidden cleared by ext reset", forbidden, 0);

        cyc(2);
        done = 1;
        summary();
        $finish;
    end

endmodule